// File: doc/BRIEF.md
# Ninth-Bit Byte Engine for Standard-Rate Private Transfers

This block is the controller-side byte engine for standard-data-rate private transfers on a two-wire bus with a clock line and a shared data line. It accepts one byte at a time over a valid/ready handshake and clocks it out, or in, over nine clock periods. The work that sets it apart is the ninth clock. For the address byte that clock carries the receiver's acknowledge. For a write it carries an odd parity bit that the controller drives. For a read it carries the target's continue/stop flag. On that flag the engine either re-drives the high level the target hands back, takes over the line when the target signals end of data, or pulls the line low while the clock is high to abort the read with a repeated START.

Each byte reports on the response interface. The response carries the eight data bits seen on the line, the level sampled on the ninth rising edge, and flags for end of data and abort. The data-line pins are a value plus two enables: a push-pull enable that drives both levels, and an open-drain enable that only pulls low when the value is 0. With neither enable set, the line is released to the pull-up. START, STOP, arbitration and command handling belong to neighbouring logic.

Top module: `sdr9_ninth_engine`

## Requirements
- R1: After reset the clock output is high, the data line is released (both enables low), tx_ready is 1 and rsp_valid is 0.
- R2: An accepted byte occupies exactly 9 clock periods of 2*HALF_CLKS cycles each. The clock is low for the first HALF_CLKS cycles of each period and high for the rest, and tx_ready stays 0 throughout.
- R3: Bits go out most significant first. A level the controller drives push-pull changes only while the clock is low, never between two consecutive high cycles.
- R4: tx_kind 0 is an address byte. Its eight bits use the open-drain enable, the ninth period is released, and the level sampled on the ninth rising edge (0 = acknowledge) is reported in rsp_ninth.
- R5: tx_kind 1 (and the unused code 3) is a write. All nine bits are push-pull, and the ninth is the odd parity bit, so the nine bits contain an odd number of ones.
- R6: tx_kind 2 is a read. The line is released for the eight data bits and for the low half of the ninth period. rsp_data holds the levels sampled on the eight rising edges, first bit in the MSB.
- R7: When a read's ninth bit is sampled high and no abort is pending, the controller drives the line high push-pull for the rest of that high phase. After the byte the clock is held low with the line driven high.
- R8: When a read's ninth bit is sampled low (end of data), the controller drives the line low push-pull for the rest of the high phase. After the byte the clock stays high and the line stays driven low, and rsp_end is 1.
- R9: When abort_req was high at the accept or during the first eight bits of a read, and the target signals continue, the controller pulls the line low through the open-drain enable after the ninth rising edge. This makes a repeated START. The clock then stays high with the line low, and rsp_abort is 1.
- R10: abort_req has no effect on address or write bytes or on a read the target ends. Pins and response are as if it were low, and rsp_abort is 0.
- R11: The push-pull and open-drain enables are never both high.
- R12: rsp_valid is a single-cycle pulse in the cycle after the byte's last clock cycle, and it carries that byte's rsp_data and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | A byte is offered |
| tx_ready | output | 1 | Engine can accept a byte |
| tx_kind | input | 2 | 0 address, 1 write, 2 read, 3 treated as write |
| tx_data | input | 8 | Byte to send (ignored for reads) |
| abort_req | input | 1 | Request repeated-START abort of the current read |
| rsp_valid | output | 1 | Response pulse at byte end |
| rsp_data | output | 8 | Eight bits seen on the line |
| rsp_ninth | output | 1 | Line level at the ninth rising edge |
| rsp_end | output | 1 | Read ended by the target |
| rsp_abort | output | 1 | Read aborted by the controller |
| scl_o | output | 1 | Clock line output |
| sda_o | output | 1 | Data line value |
| sda_pp_en | output | 1 | Push-pull enable for the data line |
| sda_od_en | output | 1 | Open-drain (pull-low) enable for the data line |
| sda_in | input | 1 | Sampled data line |

## Verification
The bench sweeps all 256 write values and checks the parity level of each. A wrong parity sense would show on every byte, because 0x00 must send a 1. All 256 read values are swept with the target continuing, and the bench checks the handoff at the ninth rising edge. A design that drove during that edge cycle, or that failed to re-drive afterwards, would produce the wrong enables in the high phase. End-of-data and aborted reads are run with various data, and the bench checks the parked line state. If a design confused those two paths, the pull-low would come from the wrong enable, or rsp_end and rsp_abort would swap. Address and write bytes are sent with abort_req raised, which exposes any engine that lets the abort leak outside reads.

// File: rtl/sdr9_pkg.sv
`timescale 1ns/1ps
package sdr9_pkg;
  typedef enum logic [1:0] {K_ADDR = 2'd0, K_WRITE = 2'd1, K_READ = 2'd2} kind_t;
  typedef enum logic [1:0] {S_FREE = 2'd0, S_BIT = 2'd1, S_GAP = 2'd2, S_HOLD = 2'd3} st_t;
endpackage

// File: rtl/sdr9_bit_timer.sv
`timescale 1ns/1ps
// Generates the clock-line phases and the bit index of one byte.
module sdr9_bit_timer #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       run,
  output logic       scl_hi,
  output logic       rise,
  output logic       late_hi,
  output logic       last,
  output logic       ninth,
  output logic       byte_done
);
  localparam int PER = 2 * HALF;
  localparam int CW  = $clog2(PER);
  localparam logic [CW-1:0] LASTC = CW'(PER - 1);
  localparam logic [CW-1:0] HALFC = CW'(HALF);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    bit_q, bit_d;

  always_comb begin
    cnt_d = cnt_q;
    bit_d = bit_q;
    if (start) begin
      cnt_d = '0;
      bit_d = 4'd0;
    end else if (run) begin
      if (cnt_q == LASTC) begin
        cnt_d = '0;
        bit_d = bit_q + 4'd1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bit_q <= 4'd0;
    end else if (start || run) begin
      cnt_q <= cnt_d;
      bit_q <= bit_d;
    end
  end

  assign scl_hi    = cnt_q >= HALFC;
  assign late_hi   = cnt_q > HALFC;
  assign rise      = run && (cnt_q == HALFC);
  assign last      = run && (cnt_q == LASTC);
  assign ninth     = bit_q == 4'd8;
  assign byte_done = last && ninth;

  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> bit_q <= 4'd8);  // R2
endmodule

// File: rtl/sdr9_shifter.sv
`timescale 1ns/1ps
// Holds the outgoing byte with its parity and collects the sampled line levels.
module sdr9_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_data,
  input  logic       shift_tx,
  input  logic       rise,
  input  logic       ninth,
  input  logic       sda_in,
  output logic       tx_bit,
  output logic       parity,
  output logic [7:0] rx_data,
  output logic       rx_ninth
);
  logic [7:0] txq, txd, rxq, rxd;
  logic       par_q, par_d, nin_q, nin_d;

  always_comb begin
    txd   = txq;
    par_d = par_q;
    rxd   = rxq;
    nin_d = nin_q;
    if (load) begin
      txd   = load_data;
      par_d = ~^load_data;
    end else if (shift_tx) begin
      txd = {txq[6:0], 1'b0};
    end
    if (rise && !ninth) rxd   = {rxq[6:0], sda_in};
    if (rise && ninth)  nin_d = sda_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txq   <= 8'd0;
      par_q <= 1'b1;
      rxq   <= 8'd0;
      nin_q <= 1'b1;
    end else begin
      if (load || shift_tx) begin
        txq   <= txd;
        par_q <= par_d;
      end
      if (rise) begin
        rxq   <= rxd;
        nin_q <= nin_d;
      end
    end
  end

  assign tx_bit   = txq[7];
  assign parity   = par_q;
  assign rx_data  = rxq;
  assign rx_ninth = nin_q;
endmodule

// File: rtl/sdr9_pin_drive.sv
`timescale 1ns/1ps
// Chooses the clock level and the data-line drive mode for each phase.
module sdr9_pin_drive
  import sdr9_pkg::*;
(
  input  st_t   st,
  input  kind_t kind,
  input  logic  ninth,
  input  logic  scl_hi,
  input  logic  late_hi,
  input  logic  tx_bit,
  input  logic  parity,
  input  logic  rx_ninth,
  input  logic  abort_q,
  output logic  scl_o,
  output logic  sda_o,
  output logic  pp_en,
  output logic  od_en
);
  always_comb begin
    scl_o = 1'b1;
    sda_o = 1'b1;
    pp_en = 1'b0;
    od_en = 1'b0;
    case (st)
      S_GAP: begin
        scl_o = 1'b0;
        pp_en = 1'b1;
      end
      S_HOLD: begin
        pp_en = 1'b1;
        sda_o = 1'b0;
      end
      S_BIT: begin
        scl_o = scl_hi;
        if (!ninth) begin
          case (kind)
            K_ADDR:  begin od_en = 1'b1; sda_o = tx_bit; end
            K_WRITE: begin pp_en = 1'b1; sda_o = tx_bit; end
            default: ;
          endcase
        end else begin
          case (kind)
            K_WRITE: begin pp_en = 1'b1; sda_o = parity; end
            K_READ: begin
              if (late_hi) begin
                if (!rx_ninth) begin
                  pp_en = 1'b1;
                  sda_o = 1'b0;
                end else if (abort_q) begin
                  od_en = 1'b1;
                  sda_o = 1'b0;
                end else begin
                  pp_en = 1'b1;
                end
              end
            end
            default: ;
          endcase
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdr9_ninth_engine.sv
`timescale 1ns/1ps
// Top: byte handshake, phase sequencing and ninth-bit outcome.
module sdr9_ninth_engine
  import sdr9_pkg::*;
#(
  parameter int HALF_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [1:0] tx_kind,
  input  logic [7:0] tx_data,
  input  logic       abort_req,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       rsp_ninth,
  output logic       rsp_end,
  output logic       rsp_abort,
  output logic       scl_o,
  output logic       sda_o,
  output logic       sda_pp_en,
  output logic       sda_od_en,
  input  logic       sda_in
);
  st_t   st_q, st_d;
  kind_t kind_q, kind_d, kin;
  logic  abort_q, abort_d;
  logic  accept, run;
  logic  scl_hi, rise, late_hi, last, ninth, byte_done;
  logic  tx_bit, parity, rx_ninth;
  logic [7:0] rx_data;
  logic  rv_d, end_d, ab_d;

  always_comb begin
    case (tx_kind)
      2'd0:    kin = K_ADDR;
      2'd2:    kin = K_READ;
      default: kin = K_WRITE;
    endcase
  end

  assign tx_ready = st_q != S_BIT;
  assign accept   = tx_valid && tx_ready;
  assign run      = st_q == S_BIT;

  sdr9_bit_timer #(.HALF(HALF_CLKS)) u_tim (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(run),
    .scl_hi(scl_hi), .rise(rise), .late_hi(late_hi), .last(last),
    .ninth(ninth), .byte_done(byte_done)
  );

  sdr9_shifter u_sh (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_data(tx_data),
    .shift_tx(last && !ninth), .rise(rise), .ninth(ninth), .sda_in(sda_in),
    .tx_bit(tx_bit), .parity(parity), .rx_data(rx_data), .rx_ninth(rx_ninth)
  );

  sdr9_pin_drive u_pin (
    .st(st_q), .kind(kind_q), .ninth(ninth), .scl_hi(scl_hi), .late_hi(late_hi),
    .tx_bit(tx_bit), .parity(parity), .rx_ninth(rx_ninth), .abort_q(abort_q),
    .scl_o(scl_o), .sda_o(sda_o), .pp_en(sda_pp_en), .od_en(sda_od_en)
  );

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    abort_d = abort_q;
    if (accept) begin
      st_d    = S_BIT;
      kind_d  = kin;
      abort_d = abort_req;
    end else if (run) begin
      if (!ninth) abort_d = abort_q | abort_req;
      if (byte_done)
        st_d = (kind_q == K_READ && (!rx_ninth || abort_q)) ? S_HOLD : S_GAP;
    end
    rv_d  = byte_done;
    end_d = (kind_q == K_READ) && !rx_ninth;
    ab_d  = (kind_q == K_READ) && rx_ninth && abort_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_FREE;
      kind_q  <= K_WRITE;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      kind_q  <= kind_d;
      abort_q <= abort_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'd0;
      rsp_ninth <= 1'b0;
      rsp_end   <= 1'b0;
      rsp_abort <= 1'b0;
    end else begin
      rsp_valid <= rv_d;
      if (byte_done) begin
        rsp_data  <= rx_data;
        rsp_ninth <= rx_ninth;
        rsp_end   <= end_d;
        rsp_abort <= ab_d;
      end
    end
  end

  AST_EN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sda_pp_en && sda_od_en));  // R11
  AST_SDA_HI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && sda_pp_en && $past(sda_pp_en)) |-> $stable(sda_o));  // R3
  AST_END_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_end) |-> (scl_o && sda_pp_en && !sda_o));  // R8
  AST_ABORT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_abort) |-> (scl_o && !sda_o && !rsp_end));  // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);  // R12
endmodule

// File: tb/sim_sdr9_ninth_engine.sv
`timescale 1ns/1ps
module sim_sdr9_ninth_engine;
  localparam int H   = 2;
  localparam int PER = 2 * H;
  localparam int NB  = 9 * PER;

  logic clk = 1'b0;
  logic rst_n, tx_valid, abort_req, tgt_en, tgt_val;
  logic [1:0] tx_kind;
  logic [7:0] tx_data;
  logic tx_ready, rsp_valid, rsp_ninth, rsp_end, rsp_abort;
  logic [7:0] rsp_data;
  logic scl_o, sda_o, sda_pp_en, sda_od_en, sda_line;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_pp_en ? sda_o :
                    (sda_od_en && !sda_o) ? 1'b0 :
                    (tgt_en ? tgt_val : 1'b1);

  sdr9_ninth_engine #(.HALF_CLKS(H)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_kind(tx_kind), .tx_data(tx_data), .abort_req(abort_req),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ninth(rsp_ninth),
    .rsp_end(rsp_end), .rsp_abort(rsp_abort), .scl_o(scl_o), .sda_o(sda_o),
    .sda_pp_en(sda_pp_en), .sda_od_en(sda_od_en), .sda_in(sda_line)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one byte; tb/tn are the target's data bits and ninth bit.
  task automatic run_byte(input int kind, input logic [7:0] d, input logic [7:0] tb,
                          input logic tn, input logic ab);
    int bad_scl, bad_en, bad_sda, bad_rdy;
    string tag;
    logic [7:0] exp_rx;
    logic exp_nin, exp_end, exp_ab, hold;
    bad_scl = 0; bad_en = 0; bad_sda = 0; bad_rdy = 0;
    if (kind == 0)      tag = "R4";
    else if (kind != 2) tag = "R5";
    else if (!tn)       tag = "R8";
    else if (ab)        tag = "R9";
    else                tag = "R7";
    tx_valid = 1'b1; tx_kind = 2'(kind); tx_data = d; abort_req = ab;
    #1;
    chk(tx_ready === 1'b1, "R2 ready before byte", int'(tx_ready), 1);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    for (int k = 0; k < NB; k++) begin
      int b, c;
      logic epp, eod, eline;
      b = k / PER;
      c = k % PER;
      tgt_en = 1'b0;
      tgt_val = 1'b1;
      if (kind == 2) begin
        if (b < 8) begin tgt_en = 1'b1; tgt_val = tb[7-b]; end
        else if (c < H || !tn) begin tgt_en = 1'b1; tgt_val = tn; end
      end else if (kind == 0 && b == 8) begin
        tgt_en = 1'b1; tgt_val = tn;
      end
      epp = 1'b0; eod = 1'b0; eline = 1'b1;
      if (kind == 0) begin
        if (b < 8) begin eod = 1'b1; eline = d[7-b]; end
        else eline = tn;
      end else if (kind == 2) begin
        if (b < 8) eline = tb[7-b];
        else if (c <= H) eline = tn;
        else if (!tn) begin epp = 1'b1; eline = 1'b0; end
        else if (ab) begin eod = 1'b1; eline = 1'b0; end
        else begin epp = 1'b1; eline = 1'b1; end
      end else begin
        epp = 1'b1;
        eline = (b < 8) ? d[7-b] : ~^d;
      end
      #1;
      if (scl_o !== (c >= H)) bad_scl++;
      if (sda_pp_en !== epp || sda_od_en !== eod) bad_en++;
      if (sda_line !== eline) bad_sda++;
      if (tx_ready !== 1'b0) bad_rdy++;
      @(negedge clk);
    end
    tgt_en = 1'b0; abort_req = 1'b0;
    #1;
    chk(bad_scl == 0, "R2 clock shape", bad_scl, 0);
    chk(bad_rdy == 0, "R2 ready low while busy", bad_rdy, 0);
    chk(bad_en == 0, {tag, " drive enables (R11)"}, bad_en, 0);
    chk(bad_sda == 0, {tag, " R3 line levels"}, bad_sda, 0);
    exp_rx  = (kind == 2) ? tb : d;
    exp_nin = (kind == 1 || kind == 3) ? ~^d : tn;
    exp_end = (kind == 2) && !tn;
    exp_ab  = (kind == 2) && tn && ab;
    hold    = exp_end || exp_ab;
    chk(rsp_valid === 1'b1, "R12 response valid", int'(rsp_valid), 1);
    chk(rsp_data === exp_rx, "R6 response data", int'(rsp_data), int'(exp_rx));
    chk(rsp_ninth === exp_nin, {tag, " ninth sample"}, int'(rsp_ninth), int'(exp_nin));
    chk(rsp_end === exp_end, "R8 end flag", int'(rsp_end), int'(exp_end));
    chk(rsp_abort === exp_ab, (ab && !exp_ab) ? "R10 abort ignored" : "R9 abort flag",
        int'(rsp_abort), int'(exp_ab));
    chk(scl_o === hold && sda_pp_en === 1'b1 && sda_od_en === 1'b0 && sda_o === !hold,
        {tag, " parked pins"}, {scl_o, sda_pp_en, sda_od_en, sda_o},
        {hold, 1'b1, 1'b0, !hold});
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R12 single pulse", int'(rsp_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0; tx_valid = 1'b0; tx_kind = 2'd0; tx_data = 8'd0;
    abort_req = 1'b0; tgt_en = 1'b0; tgt_val = 1'b1;
    repeat (3) @(negedge clk);
    chk(scl_o === 1'b1 && sda_pp_en === 1'b0 && sda_od_en === 1'b0,
        "R1 reset pins", {scl_o, sda_pp_en, sda_od_en}, 3'b100);
    chk(tx_ready === 1'b1 && rsp_valid === 1'b0, "R1 reset handshake",
        {tx_ready, rsp_valid}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++)
      run_byte(0, 8'(8'h5A + i * 37), 8'h00, 1'(i % 2), 1'b0);      // R4
    for (int v = 0; v < 256; v++)
      run_byte(1, 8'(v), 8'h00, 1'b1, 1'b0);                       // R5
    run_byte(3, 8'h81, 8'h00, 1'b1, 1'b0);                          // R5 code 3
    for (int v = 0; v < 256; v++)
      run_byte(2, 8'h00, 8'(v), 1'b1, 1'b0);                        // R6 R7
    for (int i = 0; i < 16; i++)
      run_byte(2, 8'h00, 8'(i * 17 + 3), 1'b0, 1'b0);               // R8
    for (int i = 0; i < 16; i++)
      run_byte(2, 8'h00, 8'(i * 29 + 1), 1'b1, 1'b1);               // R9
    for (int i = 0; i < 4; i++) begin                               // R10
      run_byte(0, 8'(i * 64 + 7), 8'h00, 1'b0, 1'b1);
      run_byte(1, 8'(i * 64 + 9), 8'h00, 1'b1, 1'b1);
      run_byte(2, 8'h00, 8'(i * 50), 1'b0, 1'b1);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule